// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block forms the byte a host sees when it reads a flash device while an internal program or erase is under way, or while an erase is on hold. The array read data reaches the block from the array path. The block replaces three bit positions in that data with status information and leaves every other bit unchanged.

Bit 7 is a polling bit. During a program it reads as the inverse of the value being written, and during an erase it reads as 0. Bit 6 is a general toggle bit that alternates on every read strobe while the device is busy. Bit 2 is a sector toggle bit. It alternates only for reads that fall inside the address window of the sector being erased or held, so the host can locate that sector.

The command decoder drives the inputs. It pulses `op_start` on the final write cycle of a command, holds `busy` high while the operation runs, and sets `susp` while an erase is held. The sector window is given as an inclusive low and high address. Reads are single-cycle strobes, and `rd_data` is valid in the same cycle as the strobe.

Top module: `flash_wstat_gen`

## Requirements
- R1: While `busy` is high and `op_erase` is low (program), bit 7 of `rd_data` equals the inverse of `prog_msb`.
- R2: While `busy` and `op_erase` are both high (erase), bit 7 of `rd_data` reads 0.
- R3: While `busy` is high, bit 6 of `rd_data` takes the value of a general toggle state. That state reads 0 on the first strobe after `op_start`, and each read strobe inverts it for the next read.
- R4: Once `busy` falls, with `susp` low, `rd_data` equals `arr_data` exactly on every bit, and repeated reads no longer toggle.
- R5: With `busy` low and `susp` high, a read inside the window [`sect_lo`, `sect_hi`] returns bit 7 = 1 and bit 6 = 1. Bit 2 alternates on successive in-window reads.
- R6: During an erase, bit 2 carries a sector toggle state for reads inside the inclusive window, and that state inverts on each in-window strobe. Reads outside the window return bit 2 = 1 and do not advance the sector toggle state.
- R7: A program started while `susp` is high behaves as R1 and R3. Bit 2 reads 1 outside the window, and inside the window bit 2 follows the sector toggle state.
- R8: An `op_start` pulse clears both toggle states to 0, even in the middle of a toggling sequence.
- R9: With `busy` and `susp` both low, `rd_data` equals `arr_data`. With `susp` high and `busy` low, reads outside the window also return `arr_data`.
- R10: While busy, bits 5, 4, 3, 1 and 0 of `rd_data` equal the same bits of `arr_data`.
- R11: Cycles without a read strobe leave both toggle states unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Pulse on the final write cycle of a program or erase command |
| busy | input | 1 | An internal program or erase is running |
| op_erase | input | 1 | 1 = running operation is an erase, 0 = program |
| susp | input | 1 | An erase is currently suspended |
| prog_msb | input | 1 | Bit 7 of the byte being programmed |
| sect_lo | input | ADDR_W | Lowest address of the sector being erased or held |
| sect_hi | input | ADDR_W | Highest address of the sector being erased or held |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_addr | input | ADDR_W | Read address |
| arr_data | input | DATA_W | Array data for `rd_addr` |
| rd_data | output | DATA_W | Read data with status bits merged |

## Verification
The bench builds the block with ADDR_W = 12 and DATA_W = 8. A 4 KiB address space lets a sector window sit anywhere, including a window that covers every address from 0 to the top. With that width, the inclusive edges of the window can be read at the low end, the high end, one below and one above. A whole-array erase window can also be exercised at both extreme addresses.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

    localparam int POLL_POS = 7;
    localparam int TGL_POS  = 6;
    localparam int SECT_POS = 2;
    localparam int NUM_TGL  = 2;
    localparam int TGL_ALL  = 0;
    localparam int TGL_SECT = 1;

    typedef enum logic [1:0] {
        MODE_PASS  = 2'd0,
        MODE_PROG  = 2'd1,
        MODE_ERASE = 2'd2,
        MODE_HOLD  = 2'd3
    } wsg_mode_e;

    typedef struct packed {
        logic sect;
        logic all;
    } wsg_tgl_s;

    typedef struct packed {
        wsg_mode_e mode;
        logic      hit;
        logic      held;
    } wsg_ctx_s;

    function automatic wsg_mode_e pick_mode(input logic busy,
                                            input logic is_erase,
                                            input logic held);
        if (busy)
            return is_erase ? MODE_ERASE : MODE_PROG;
        else if (held)
            return MODE_HOLD;
        else
            return MODE_PASS;
    endfunction

endpackage

// File: rtl/wsg_sect_match.sv
module wsg_sect_match #(
    parameter int ADDR_W = 21
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic              hit
);
    logic above_lo;
    logic below_hi;

    always_comb begin
        above_lo = (addr >= lo);
        below_hi = (addr <= hi);
        hit      = above_lo && below_hi;
    end
endmodule

// File: rtl/wsg_toggle_unit.sv
module wsg_toggle_unit (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= 1'b0;
        else if (adv)
            q <= ~q;
    end
endmodule

// File: rtl/wsg_status_mux.sv
module wsg_status_mux
    import wsg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  wsg_ctx_s          ctx,
    input  wsg_tgl_s          tgl,
    input  logic              prog_msb,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] dout
);
    always_comb begin
        dout = arr_data;
        unique case (ctx.mode)
            MODE_PROG: begin
                dout[POLL_POS] = ~prog_msb;
                dout[TGL_POS]  = tgl.all;
                dout[SECT_POS] = (ctx.held && ctx.hit) ? tgl.sect : 1'b1;
            end
            MODE_ERASE: begin
                dout[POLL_POS] = 1'b0;
                dout[TGL_POS]  = tgl.all;
                dout[SECT_POS] = ctx.hit ? tgl.sect : 1'b1;
            end
            MODE_HOLD: begin
                if (ctx.hit) begin
                    dout[POLL_POS] = 1'b1;
                    dout[TGL_POS]  = 1'b1;
                    dout[SECT_POS] = tgl.sect;
                end
            end
            default: dout = arr_data;
        endcase
    end
endmodule

// File: rtl/flash_wstat_gen.sv
module flash_wstat_gen
    import wsg_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_start,
    input  logic              busy,
    input  logic              op_erase,
    input  logic              susp,
    input  logic              prog_msb,
    input  logic [ADDR_W-1:0] sect_lo,
    input  logic [ADDR_W-1:0] sect_hi,
    input  logic              rd_stb,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int MIN_DATA_W = POLL_POS + 1;

    logic               hit;
    logic [NUM_TGL-1:0] tgl_adv;
    logic [NUM_TGL-1:0] tgl_q;
    wsg_ctx_s           ctx;
    wsg_tgl_s           tgl;

    initial begin
        if (DATA_W < MIN_DATA_W)
            $error("DATA_W too narrow for status bit positions");
    end

    wsg_sect_match #(.ADDR_W(ADDR_W)) u_match (
        .addr (rd_addr),
        .lo   (sect_lo),
        .hi   (sect_hi),
        .hit  (hit)
    );

    always_comb begin
        ctx.mode = pick_mode(busy, op_erase, susp);
        ctx.hit  = hit;
        ctx.held = susp;
        tgl_adv[TGL_ALL]  = rd_stb && busy;
        tgl_adv[TGL_SECT] = rd_stb && hit && (susp || (busy && op_erase));
    end

    for (genvar gi = 0; gi < NUM_TGL; gi++) begin : g_tgl
        wsg_toggle_unit u_tgl (
            .clk (clk),
            .rst (rst),
            .clr (op_start),
            .adv (tgl_adv[gi]),
            .q   (tgl_q[gi])
        );
    end

    always_comb begin
        tgl.all  = tgl_q[TGL_ALL];
        tgl.sect = tgl_q[TGL_SECT];
    end

    wsg_status_mux #(.DATA_W(DATA_W)) u_mux (
        .ctx      (ctx),
        .tgl      (tgl),
        .prog_msb (prog_msb),
        .arr_data (arr_data),
        .dout     (rd_data)
    );
endmodule

// File: rtl/wsg_checker.sv
module wsg_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              op_start,
    input logic              busy,
    input logic              op_erase,
    input logic              susp,
    input logic              prog_msb,
    input logic              rd_stb,
    input logic              hit,
    input logic [1:0]        tgl_q,
    input logic [DATA_W-1:0] arr_data,
    input logic [DATA_W-1:0] rd_data
);
    AST_PROG_POLL: assert property (@(posedge clk) disable iff (rst)
        (busy && !op_erase) |-> (rd_data[7] == !prog_msb)); // R1

    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (rst)
        (busy && op_erase) |-> (rd_data[7] == 1'b0)); // R2

    AST_ALL_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && busy && !op_start) |=> (tgl_q[0] != $past(tgl_q[0]))); // R3

    AST_HOLD_FIXED: assert property (@(posedge clk) disable iff (rst)
        (!busy && susp && hit) |-> (rd_data[7] && rd_data[6])); // R5

    AST_OUTSIDE_KEEP: assert property (@(posedge clk) disable iff (rst)
        (busy && op_erase && !hit && !op_start) |=> $stable(tgl_q[1])); // R6

    AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
        op_start |=> (tgl_q == 2'b00)); // R8

    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
        (!busy && !susp) |-> (rd_data == arr_data)); // R9

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rd_stb && !op_start) |=> $stable(tgl_q)); // R11
endmodule

bind flash_wstat_gen wsg_checker #(.DATA_W(DATA_W)) u_wsg_checker (
    .clk      (clk),
    .rst      (rst),
    .op_start (op_start),
    .busy     (busy),
    .op_erase (op_erase),
    .susp     (susp),
    .prog_msb (prog_msb),
    .rd_stb   (rd_stb),
    .hit      (hit),
    .tgl_q    (tgl_q),
    .arr_data (arr_data),
    .rd_data  (rd_data)
);

// File: tb/test_flash_wstat_gen.sv
module test_flash_wstat_gen;
    localparam int AW = 12;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          op_start = 1'b0;
    logic          busy = 1'b0;
    logic          op_erase = 1'b0;
    logic          susp = 1'b0;
    logic          prog_msb = 1'b0;
    logic [AW-1:0] sect_lo = '0;
    logic [AW-1:0] sect_hi = '0;
    logic          rd_stb = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] arr_data;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign arr_data = rd_addr[7:0] ^ 8'hC3;

    flash_wstat_gen #(.ADDR_W(AW), .DATA_W(DW)) i_flash_wstat_gen (
        .clk(clk), .rst(rst), .op_start(op_start), .busy(busy),
        .op_erase(op_erase), .susp(susp), .prog_msb(prog_msb),
        .sect_lo(sect_lo), .sect_hi(sect_hi), .rd_stb(rd_stb),
        .rd_addr(rd_addr), .arr_data(arr_data), .rd_data(rd_data)
    );

    function automatic logic [7:0] pattern(input logic [AW-1:0] a);
        return a[7:0] ^ 8'hC3;
    endfunction

    function automatic logic [7:0] merged(input logic [AW-1:0] a,
                                          input logic b7, input logic b6,
                                          input logic b2);
        logic [7:0] v;
        v = pattern(a);
        v[7] = b7;
        v[6] = b6;
        v[2] = b2;
        return v;
    endfunction

    task automatic chk(input string req, input logic [7:0] got,
                       input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_stb  = 1'b1;
        rd_addr = a;
        #2 v = rd_data;
        @(posedge clk);
        #1 rd_stb = 1'b0;
    endtask

    task automatic start_op(input logic is_erase, input logic msb);
        @(negedge clk);
        op_start = 1'b1;
        busy     = 1'b1;
        op_erase = is_erase;
        prog_msb = msb;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    task automatic finish_op();
        @(negedge clk);
        busy = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_read(12'h055, v);
        chk("R9 idle pass", v, pattern(12'h055));
        do_read(12'h055, v);
        chk("R9 idle repeat", v, pattern(12'h055));
    endtask

    task automatic t_program();
        logic [7:0] v;
        start_op(1'b0, 1'b0);
        do_read(12'h010, v);
        chk("R1 R3 R10 prog first", v, merged(12'h010, 1'b1, 1'b0, 1'b1));
        do_read(12'h010, v);
        chk("R3 prog second", v, merged(12'h010, 1'b1, 1'b1, 1'b1));
        repeat (3) @(negedge clk);
        do_read(12'h024, v);
        chk("R11 R10 no strobe gap", v, merged(12'h024, 1'b1, 1'b0, 1'b1));
        finish_op();
        do_read(12'h010, v);
        chk("R4 done true data", v, pattern(12'h010));
        do_read(12'h010, v);
        chk("R4 done stable", v, pattern(12'h010));
        start_op(1'b0, 1'b1);
        do_read(12'h0F0, v);
        chk("R1 prog msb one", v, merged(12'h0F0, 1'b0, 1'b0, 1'b1));
        finish_op();
    endtask

    task automatic t_erase();
        logic [7:0] v;
        sect_lo = 12'h100;
        sect_hi = 12'h1FF;
        start_op(1'b1, 1'b0);
        do_read(12'h100, v);
        chk("R2 R6 erase low edge", v, merged(12'h100, 1'b0, 1'b0, 1'b0));
        do_read(12'h0FF, v);
        chk("R6 below window", v, merged(12'h0FF, 1'b0, 1'b1, 1'b1));
        do_read(12'h1FF, v);
        chk("R6 high edge", v, merged(12'h1FF, 1'b0, 1'b0, 1'b1));
        do_read(12'h200, v);
        chk("R6 above window", v, merged(12'h200, 1'b0, 1'b1, 1'b1));
        do_read(12'h180, v);
        chk("R6 inside again", v, merged(12'h180, 1'b0, 1'b0, 1'b0));
        finish_op();
        do_read(12'h180, v);
        chk("R4 erase done", v, pattern(12'h180));
    endtask

    task automatic t_suspend();
        logic [7:0] v;
        logic [7:0] w;
        logic [7:0] x;
        @(negedge clk);
        susp = 1'b1;
        do_read(12'h140, v);
        chk("R5 held bits", v & 8'hC0, 8'hC0);
        chk("R5 held others", v & 8'h3B, pattern(12'h140) & 8'h3B);
        do_read(12'h140, w);
        chk("R5 held toggles", w, {v[7:3], ~v[2], v[1:0]});
        do_read(12'h300, x);
        chk("R9 held outside pass", x, pattern(12'h300));
        do_read(12'h140, x);
        chk("R5 outside no advance", x, v);
    endtask

    task automatic t_prog_in_susp();
        logic [7:0] v;
        start_op(1'b0, 1'b1);
        do_read(12'h300, v);
        chk("R7 R8 other sector", v, merged(12'h300, 1'b0, 1'b0, 1'b1));
        do_read(12'h140, v);
        chk("R7 held sector", v, merged(12'h140, 1'b0, 1'b1, 1'b0));
        do_read(12'h140, v);
        chk("R7 held sector again", v, merged(12'h140, 1'b0, 1'b0, 1'b1));
        finish_op();
        do_read(12'h140, v);
        chk("R5 back to hold", v, merged(12'h140, 1'b1, 1'b1, 1'b0));
        @(negedge clk);
        susp = 1'b0;
    endtask

    task automatic t_restart();
        logic [7:0] v;
        start_op(1'b0, 1'b0);
        do_read(12'h033, v);
        chk("R3 before restart", v, merged(12'h033, 1'b1, 1'b0, 1'b1));
        start_op(1'b0, 1'b0);
        do_read(12'h033, v);
        chk("R8 restart clears", v, merged(12'h033, 1'b1, 1'b0, 1'b1));
        finish_op();
    endtask

    task automatic t_chip();
        logic [7:0] v;
        sect_lo = 12'h000;
        sect_hi = 12'hFFF;
        start_op(1'b1, 1'b0);
        do_read(12'h000, v);
        chk("R6 full window bottom", v, merged(12'h000, 1'b0, 1'b0, 1'b0));
        do_read(12'hFFF, v);
        chk("R6 full window top", v, merged(12'hFFF, 1'b0, 1'b1, 1'b1));
        finish_op();
        do_read(12'hFFF, v);
        chk("R4 chip done", v, pattern(12'hFFF));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_program();
        t_erase();
        t_suspend();
        t_prog_in_susp();
        t_restart();
        t_chip();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule